// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block gathers per-channel event pulses from a multichannel DMA engine and makes them visible to software through a small register port. Every channel raises three kinds of event: a transfer-done pulse and two separate error pulses (class A and class B). Each pulse sets a sticky raw bit. A per-class enable register selects which channels may interrupt. The block offers three views of the state: the raw bits, the enabled (masked) bits per class, and one summary word in which a channel's bit is set when any enabled source of that channel is pending. A single level interrupt line is high while the summary is nonzero.

Software clears sticky bits by writing ones to a class's raw register. Zero bits in that write leave the matching raw bits alone. A channel that is being stopped can be cleaned up by clearing its bit in all three raw registers one after the other. Reads go through a two-state access sequencer. In `ACC_IDLE`, a read request captures the addressed word and moves to `ACC_RDATA`. `ACC_RDATA` raises the read-valid strobe. It stays in `ACC_RDATA` while reads keep arriving back to back and returns to `ACC_IDLE` on the first cycle without one. Writes take effect at the clock edge that samples them and produce no strobe.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset, every raw bit and every enable bit is zero, `irq_o` is low, `rd_valid_o` is low, and all registers read as zero.
- R2: An event pulse on channel bit i of a class sets raw bit i of that class at the sampling edge. The bit stays set until software clears it.
- R3: A write to a raw register (transfer-done 0x600, error A 0x608, error B 0x610) clears every raw bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R4: When an event and a clear hit the same raw bit in the same cycle, the event wins and the bit remains set.
- R5: The per-class enabled-status registers (transfer-done 0x04, error A 0x0C, error B 0x10) read as raw AND enable for that class, in bits [15:0].
- R6: The summary register at 0x00 reads, per channel bit, the OR of the three enabled-status values.
- R7: The enable registers (transfer-done 0x18, error A 0x20, error B 0x24) take write-data bits [15:0], where 1 enables a channel. They read back those bits, with bits [31:16] reading zero.
- R8: `irq_o` is a level output that is high exactly when the summary value is nonzero. Raw bits whose enable is 0 do not raise it.
- R9: A read request (`rd_req_i` with `rd_wr_i`=0) raises `rd_valid_o` on the following cycle. `rd_data_o` then holds the register value as it stood before the edge that sampled the request. `rd_valid_o` is low in any cycle that does not follow a read request.
- R10: Reads of unmapped addresses return zero. Writes to status, summary or unmapped addresses change no state.
- R11: The raw registers read back the sticky bits regardless of the enable setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_done_i | input | 16 | Transfer-done pulses, one bit per channel |
| evt_erra_i | input | 16 | Error class A pulses, one bit per channel |
| evt_errb_i | input | 16 | Error class B pulses, one bit per channel |
| rd_req_i | input | 1 | Register access request |
| rd_wr_i | input | 1 | 1 = write, 0 = read |
| rd_addr_i | input | 12 | Byte address of the register |
| rd_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded properties check, on every cycle, several rules that hold at all times:
- every event bit is latched on the next edge, even against a same-cycle clear;
- no raw bit appears without an event;
- a clear without a competing event empties its bits;
- enable registers move only on their own writes;
- the read strobe follows read requests exactly;
- the interrupt never rises with all enables off or with no raw bit set.

The register map itself can only be shown by the bench's scenarios. This covers:
- which offset returns which view;
- the OR across classes in the summary;
- the zero reads of unmapped addresses;
- the absence of effect from writes to read-only offsets;
- the snapshot timing of read data against a simultaneous event.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int NUM_CLASSES = 3;

    typedef enum logic [1:0] {
        CLS_DONE = 2'd0,
        CLS_ERRA = 2'd1,
        CLS_ERRB = 2'd2
    } evt_class_e;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_RDATA = 1'b1
    } acc_state_e;

    localparam logic [11:0] OFS_SUMMARY = 12'h000;

    localparam logic [11:0] OFS_STAT [NUM_CLASSES] = '{12'h004, 12'h00C, 12'h010};
    localparam logic [11:0] OFS_EN   [NUM_CLASSES] = '{12'h018, 12'h020, 12'h024};
    localparam logic [11:0] OFS_RAW  [NUM_CLASSES] = '{12'h600, 12'h608, 12'h610};

endpackage

// File: rtl/dma_irq_src_bank.sv
module dma_irq_src_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] masked
);

    logic [NUM_CH-1:0] clr_vec;

    always_comb begin
        clr_vec = clr_we ? wbits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= '0;
        end else begin
            raw <= (raw & ~clr_vec) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else if (en_we) begin
            en <= wbits;
        end
    end

    always_comb begin
        masked = raw & en;
    end

    // R2 R4
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & ~$past(raw) & ~$past(evt)) == '0));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((wbits & ~evt) != '0)) |=> ((raw & $past(wbits & ~evt)) == '0));

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(en));

endmodule

// File: rtl/dma_irq_reg_port.sv
module dma_irq_reg_port
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req,
    input  logic                               wr,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0] raw,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0] en,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0] masked,
    input  logic [NUM_CH-1:0]                  summary,
    output logic [NUM_CLASSES-1:0]             clr_we,
    output logic [NUM_CLASSES-1:0]             en_we,
    output logic [NUM_CH-1:0]                  wbits,
    output logic [DATA_W-1:0]                  rdata,
    output logic                               rvalid
);

    acc_state_e        state_q, state_d;
    logic              rd_req, wr_req;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_req = req && !wr;
        wr_req = req && wr;
        wbits  = wdata[NUM_CH-1:0];
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_dec
        always_comb begin
            clr_we[c] = wr_req && (addr == ADDR_W'(OFS_RAW[c]));
            en_we[c]  = wr_req && (addr == ADDR_W'(OFS_EN[c]));
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(OFS_SUMMARY)) begin
            rd_val = DATA_W'(summary);
        end
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (addr == ADDR_W'(OFS_STAT[c])) rd_val = DATA_W'(masked[c]);
            if (addr == ADDR_W'(OFS_EN[c]))   rd_val = DATA_W'(en[c]);
            if (addr == ADDR_W'(OFS_RAW[c]))  rd_val = DATA_W'(raw[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (rd_req) state_d = ACC_RDATA;
            ACC_RDATA: state_d = rd_req ? ACC_RDATA : ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= rd_val;
        end
    end

    always_comb begin
        rvalid = (state_q == ACC_RDATA);
    end

    // R9
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);

    // R9
    rvalid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);

    // R10
    write_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_we, en_we}));

endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0] masked,
    output logic [NUM_CH-1:0]                  summary,
    output logic                               irq
);

    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            summary = summary | masked[c];
        end
        irq = |summary;
    end

endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_done_i,
    input  logic [NUM_CH-1:0] evt_erra_i,
    input  logic [NUM_CH-1:0] evt_errb_i,
    input  logic              rd_req_i,
    input  logic              rd_wr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] rd_wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              irq_o
);

    logic [NUM_CLASSES-1:0][NUM_CH-1:0] evt_all;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] raw_all;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] en_all;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] masked_all;
    logic [NUM_CLASSES-1:0]             clr_we;
    logic [NUM_CLASSES-1:0]             en_we;
    logic [NUM_CH-1:0]                  wbits;
    logic [NUM_CH-1:0]                  summary;

    always_comb begin
        evt_all[CLS_DONE] = evt_done_i;
        evt_all[CLS_ERRA] = evt_erra_i;
        evt_all[CLS_ERRB] = evt_errb_i;
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bank
        dma_irq_src_bank #(.NUM_CH(NUM_CH)) bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_all[c]),
            .clr_we (clr_we[c]),
            .en_we  (en_we[c]),
            .wbits  (wbits),
            .raw    (raw_all[c]),
            .en     (en_all[c]),
            .masked (masked_all[c])
        );
    end

    dma_irq_combine #(.NUM_CH(NUM_CH)) comb_i (
        .masked  (masked_all),
        .summary (summary),
        .irq     (irq_o)
    );

    dma_irq_reg_port #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) port_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rd_req_i),
        .wr      (rd_wr_i),
        .addr    (rd_addr_i),
        .wdata   (rd_wdata_i),
        .raw     (raw_all),
        .en      (en_all),
        .masked  (masked_all),
        .summary (summary),
        .clr_we  (clr_we),
        .en_we   (en_we),
        .wbits   (wbits),
        .rdata   (rd_data_o),
        .rvalid  (rd_valid_o)
    );

    // R8
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw_all != '0));

    // R8
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> !irq_o);

endmodule

// File: tb/dma_irq_aggregator_tb.sv
module dma_irq_aggregator_tb_top;

    localparam int NCH = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] evt_done = '0, evt_erra = '0, evt_errb = '0;
    logic           req = 1'b0, wr = 1'b0;
    logic [11:0]    addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic           rvalid, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_irq_aggregator dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_done_i (evt_done),
        .evt_erra_i (evt_erra),
        .evt_errb_i (evt_errb),
        .rd_req_i   (req),
        .rd_wr_i    (wr),
        .rd_addr_i  (addr),
        .rd_wdata_i (wdata),
        .rd_data_o  (rdata),
        .rd_valid_o (rvalid),
        .irq_o      (irq)
    );

    // kind: 0 write, 1 read and compare, 2 event (addr = class 0/1/2, data = bits)
    localparam int NV = 29;
    localparam logic [81:0] VEC [NV] = '{
        {2'd1, 12'h018, 32'h0,        32'h0,    4'd1},  // R1
        {2'd1, 12'h600, 32'h0,        32'h0,    4'd1},  // R1
        {2'd2, 12'h000, 32'h0005,     32'h0,    4'd2},
        {2'd1, 12'h600, 32'h0,        32'h0005, 4'd2},  // R2
        {2'd1, 12'h004, 32'h0,        32'h0,    4'd5},  // R5
        {2'd1, 12'h000, 32'h0,        32'h0,    4'd6},  // R6
        {2'd0, 12'h018, 32'hFFFFFFFF, 32'h0,    4'd7},
        {2'd1, 12'h018, 32'h0,        32'hFFFF, 4'd7},  // R7
        {2'd1, 12'h004, 32'h0,        32'h0005, 4'd5},  // R5
        {2'd1, 12'h000, 32'h0,        32'h0005, 4'd6},  // R6
        {2'd2, 12'h001, 32'h0100,     32'h0,    4'd2},
        {2'd1, 12'h608, 32'h0,        32'h0100, 4'd11}, // R11
        {2'd1, 12'h00C, 32'h0,        32'h0,    4'd5},  // R5
        {2'd0, 12'h020, 32'h0100,     32'h0,    4'd7},
        {2'd1, 12'h00C, 32'h0,        32'h0100, 4'd5},  // R5
        {2'd1, 12'h000, 32'h0,        32'h0105, 4'd6},  // R6
        {2'd2, 12'h002, 32'h8001,     32'h0,    4'd2},
        {2'd0, 12'h024, 32'h8000,     32'h0,    4'd7},
        {2'd1, 12'h010, 32'h0,        32'h8000, 4'd5},  // R5
        {2'd1, 12'h000, 32'h0,        32'h8105, 4'd6},  // R6
        {2'd0, 12'h600, 32'h0004,     32'h0,    4'd3},
        {2'd1, 12'h600, 32'h0,        32'h0001, 4'd3},  // R3
        {2'd0, 12'h610, 32'h0,        32'h0,    4'd3},
        {2'd1, 12'h610, 32'h0,        32'h8001, 4'd3},  // R3
        {2'd1, 12'h014, 32'h0,        32'h0,    4'd10}, // R10
        {2'd0, 12'h000, 32'hFFFF,     32'h0,    4'd10},
        {2'd1, 12'h000, 32'h0,        32'h8101, 4'd10}, // R10
        {2'd0, 12'h014, 32'h0,        32'h0,    4'd10},
        {2'd1, 12'h018, 32'h0,        32'hFFFF, 4'd10}  // R10
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata;
        v = rvalid;
    endtask

    task automatic do_event(input logic [1:0] cls, input logic [NCH-1:0] bits);
        @(negedge clk);
        case (cls)
            2'd0:    evt_done = bits;
            2'd1:    evt_erra = bits;
            default: evt_errb = bits;
        endcase
        @(negedge clk);
        evt_done = '0; evt_erra = '0; evt_errb = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        chk("R1", {31'b0, irq}, 32'h0);
        chk("R1", {31'b0, rvalid}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [11:0] a;
            logic [31:0] dv, ev;
            logic [3:0]  r;
            {k, a, dv, ev, r} = VEC[i];
            if (k == 2'd0) do_write(a, dv);
            else if (k == 2'd2) do_event(a[1:0], dv[NCH-1:0]);
            else begin
                do_read(a, d, v);
                chk($sformatf("R%0d vector %0d", r, i), d, ev);
            end
        end

        // R8 interrupt level follows the summary
        @(negedge clk);
        chk("R8 irq with pending", {31'b0, irq}, 32'h1);
        do_write(12'h600, 32'hFFFF);
        do_write(12'h608, 32'hFFFF);
        do_write(12'h610, 32'hFFFF);
        chk("R8 irq after clearing all", {31'b0, irq}, 32'h0);
        do_read(12'h000, d, v);
        chk("R3 summary after clearing all", d, 32'h0);

        // R8 disabled source does not raise irq
        do_write(12'h018, 32'h0);
        do_event(2'd0, 16'h0040);
        chk("R8 irq with source disabled", {31'b0, irq}, 32'h0);
        do_read(12'h600, d, v);
        chk("R11 raw kept while disabled", d, 32'h0040);
        do_write(12'h018, 32'h0040);
        chk("R8 irq after enabling", {31'b0, irq}, 32'h1);

        // R4 event and clear in the same cycle
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 12'h600; wdata = 32'h0048; evt_done = 16'h0008;
        @(negedge clk);
        req = 1'b0; wr = 1'b0; evt_done = '0;
        do_read(12'h600, d, v);
        chk("R4 event beats clear", d, 32'h0008);

        // R9 read snapshot and strobe timing
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 12'h608; evt_erra = 16'h0002;
        @(negedge clk);
        req = 1'b0; evt_erra = '0;
        chk("R9 rvalid after read", {31'b0, rvalid}, 32'h1);
        chk("R9 data before event", rdata, 32'h0);
        @(negedge clk);
        chk("R9 rvalid drops", {31'b0, rvalid}, 32'h0);
        do_write(12'h020, 32'h0002);
        chk("R9 no strobe on write", {31'b0, rvalid}, 32'h0);
        do_read(12'h608, d, v);
        chk("R9 rvalid on second read", {31'b0, v}, 32'h1);
        chk("R2 event latched", d, 32'h0002);
        do_read(12'h700, d, v);
        chk("R10 unmapped read", d, 32'h0);

        // R1 reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        do_read(12'h020, d, v);
        chk("R1 enable after reset", d, 32'h0);
        do_read(12'h608, d, v);
        chk("R1 raw after reset", d, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule